// File: doc/BRIEF.md
# Pulse-Per-Second Pin Output and Timestamp Capture Unit

This unit sits on one bidirectional timing pin and works against a free-running time counter supplied by its host. In periodic output mode it drives a square wave whose high half is the larger half of a programmable period, starting exactly when the time counter reaches a programmed future start time. Every half-period boundary is computed from the start time, so the wave stays locked to the counter's phase and does not accumulate drift.

In oneshot mode a single pulse leaves the pin as soon as the command is accepted, and the counter value at that moment is stored in the timestamp register. In capture mode the pin is released (output enable low), its level is brought through a synchronizer, and each rising edge stores the counter value in that same timestamp register. No queue and no interrupt exist: the newest event replaces the previous one, and a sticky flag reports that an unread value is waiting.

Software programs the start time, the period and a control word through a small write port, then reads the timestamp with a read strobe that clears the flag.

Top module: `pps_pin_unit`

## Requirements
- R1: After reset the pin output is low, output enable is high, the timestamp is 0 and the new-value flag is 0.
- R2: A periodic arm is taken when a control write carries enable=1 and mode=0. If the start time is greater than the time value seen at that edge, the pin goes high after the first clock edge where the time value is at least the start time. If the start time is not greater, the pin stays low and never starts.
- R3: A running periodic output with effective period E is high for E-(E/2) time units and low for E/2 units, repeating from the start time. A programmed period below 2 is treated as 2.
- R4: Control writes carry enable in bit 0 and mode in bits 2:1. Enable=1 with mode=2 fires a oneshot: the pin is high for ONESHOT_W cycles after the command edge, the timestamp takes the time value seen at that edge, and the flag is set.
- R5: With enable=1 and mode=1 (capture), a rising level on pin_in stores the time value seen at the third clock edge after the change. A later capture overwrites the earlier one. Falling edges store nothing.
- R6: In capture mode pin_oe and pin_out are low. In any other mode, changes on pin_in leave the timestamp and the flag unchanged.
- R7: A read strobe clears the flag. If a new value is stored on the same edge, the flag stays set.
- R8: A control write with enable=0 drives the pin low and stops all toggling until the unit is armed again.
- R9: Write address 1 holds the start time and address 2 the period. Mode 3 with enable=1 behaves as disabled: the pin is low and output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | TW | Current value of the time counter |
| cfg_we | input | 1 | Write strobe of the control port |
| cfg_addr | input | 2 | Write address: 0 control, 1 start, 2 period |
| cfg_wdata | input | TW | Write data |
| ts_rd | input | 1 | Timestamp read strobe; clears the flag |
| ts_value | output | TW | Latched timestamp |
| ts_new | output | 1 | Sticky flag: unread timestamp present |
| pin_in | input | 1 | Level sensed on the pin |
| pin_out | output | 1 | Level driven on the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The periodic output is swept over every period from 1 to 7 (even, odd and the clamped value). Each period is tried with start offsets of 0, 1 and 5 from the arming time. The zero offset shows that a start time equal to the current time never starts. Offset 1 catches an off-by-one at the start edge. The odd periods separate the high half from the low half. Capture is tried with a rising edge, a falling edge, an overwriting second edge, a read strobe on the same edge as a store, and edges arriving in non-capture modes. Together these separate a wrong capture latency, edge polarity or mode gating.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    MD_PERIODIC = 2'd0,
    MD_CAPTURE  = 2'd1,
    MD_ONESHOT  = 2'd2,
    MD_RSVD     = 2'd3
  } pin_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STALE,
    ST_RUN,
    ST_PULSE
  } wave_st_t;

  // Periods below two cannot hold both halves, so clamp.
  function automatic logic [63:0] eff_period(input logic [63:0] p);
    return (p < 64'd2) ? 64'd2 : p;
  endfunction

  function automatic logic [63:0] high_len(input logic [63:0] p);
    logic [63:0] e;
    e = eff_period(p);
    return e - (e >> 1);
  endfunction

  function automatic logic [63:0] low_len(input logic [63:0] p);
    return eff_period(p) >> 1;
  endfunction

endpackage

// File: rtl/pps_in_sync.sv
module pps_in_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_N-1:0], pin_i};
  end

  assign rise_o = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
endmodule

// File: rtl/pps_wave_gen.sv
module pps_wave_gen
  import pps_pkg::*;
#(
  parameter int TW        = 32,
  parameter int ONESHOT_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          en_i,
  input  pin_mode_t     mode_i,
  input  logic [TW-1:0] start_i,
  input  logic [TW-1:0] period_i,
  input  logic [TW-1:0] time_i,
  output logic          wave_o,
  output logic          fire_o
);
  localparam int CW = $clog2(ONESHOT_W + 1);

  wave_st_t       st_q;
  logic           wave_q;
  logic [TW-1:0]  start_q;
  logic [TW-1:0]  hi_q;
  logic [TW-1:0]  lo_q;
  logic [TW-1:0]  edge_q;
  logic [CW-1:0]  cnt_q;
  logic           reached_start;
  logic           reached_edge;

  assign fire_o        = arm_i && en_i && (mode_i == MD_ONESHOT);
  assign reached_start = (time_i >= start_q);
  assign reached_edge  = (time_i >= edge_q);
  assign wave_o        = wave_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wave_q  <= 1'b0;
      start_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      edge_q  <= '0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      wave_q  <= 1'b0;
      st_q    <= ST_IDLE;
      start_q <= start_i;
      hi_q    <= TW'(high_len(64'(period_i)));
      lo_q    <= TW'(low_len(64'(period_i)));
      if (en_i && mode_i == MD_PERIODIC) begin
        st_q <= (start_i > time_i) ? ST_WAIT : ST_STALE;
      end else if (fire_o) begin
        st_q   <= ST_PULSE;
        wave_q <= 1'b1;
        cnt_q  <= CW'(ONESHOT_W - 1);
      end
    end else begin
      case (st_q)
        ST_WAIT: if (reached_start) begin
          st_q   <= ST_RUN;
          wave_q <= 1'b1;
          edge_q <= start_q + hi_q;
        end
        ST_RUN: if (reached_edge) begin
          wave_q <= ~wave_q;
          edge_q <= edge_q + (wave_q ? lo_q : hi_q);
        end
        ST_PULSE: begin
          if (cnt_q == '0) begin
            st_q   <= ST_IDLE;
            wave_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && $rose(wave_q) && $past(st_q) == ST_WAIT) |-> ($past(time_i) >= start_q)); // R2

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && $past(st_q) == ST_RUN && wave_q != $past(wave_q)) |-> ($past(time_i) >= $past(edge_q))); // R3
endmodule

// File: rtl/pps_stamp_reg.sv
module pps_stamp_reg #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_ev,
  input  logic          shot_ev,
  input  logic          rd_i,
  input  logic [TW-1:0] time_i,
  output logic [TW-1:0] ts_o,
  output logic          new_o
);
  logic latch_ev;
  assign latch_ev = cap_ev | shot_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_o  <= '0;
      new_o <= 1'b0;
    end else begin
      if (latch_ev) ts_o <= time_i;
      if (latch_ev)  new_o <= 1'b1;
      else if (rd_i) new_o <= 1'b0;
    end
  end

  AST_LATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ev |=> new_o); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !latch_ev) |=> !new_o); // R7
endmodule

// File: rtl/pps_pin_unit.sv
module pps_pin_unit
  import pps_pkg::*;
#(
  parameter int TW        = 32,
  parameter int ONESHOT_W = 4,
  parameter int SYNC_N    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          ts_rd,
  output logic [TW-1:0] ts_value,
  output logic          ts_new,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe
);
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_START = 2'd1;
  localparam logic [1:0] A_PER   = 2'd2;

  logic          en_q;
  pin_mode_t     mode_q;
  logic [TW-1:0] start_q;
  logic [TW-1:0] period_q;
  logic          arm;
  logic          w_en;
  pin_mode_t     w_mode;
  logic          cap_mode;
  logic          rise;
  logic          cap_ev;
  logic          fire;
  logic          wave;

  assign arm    = cfg_we && (cfg_addr == A_CTRL);
  assign w_en   = cfg_wdata[0];
  assign w_mode = pin_mode_t'(cfg_wdata[2:1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      mode_q   <= MD_PERIODIC;
      start_q  <= '0;
      period_q <= TW'(2);
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL: begin
          en_q   <= w_en;
          mode_q <= w_mode;
        end
        A_START: start_q  <= cfg_wdata;
        A_PER:   period_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  assign cap_mode = en_q && (mode_q == MD_CAPTURE);
  assign cap_ev   = cap_mode && rise;

  pps_in_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_in),
    .rise_o (rise)
  );

  pps_wave_gen #(.TW(TW), .ONESHOT_W(ONESHOT_W)) u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm),
    .en_i     (w_en),
    .mode_i   (w_mode),
    .start_i  (start_q),
    .period_i (period_q),
    .time_i   (time_now),
    .wave_o   (wave),
    .fire_o   (fire)
  );

  pps_stamp_reg #(.TW(TW)) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_ev  (cap_ev),
    .shot_ev (fire),
    .rd_i    (ts_rd),
    .time_i  (time_now),
    .ts_o    (ts_value),
    .new_o   (ts_new)
  );

  assign pin_out = wave;
  assign pin_oe  = !cap_mode;

  AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mode |-> !pin_out); // R6

  AST_SHOT_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ts_value == $past(time_now) && ts_new)); // R4
endmodule

// File: tb/sim_pps_pin_unit.sv
module sim_pps_pin_unit;
  localparam int CLK_NS = 10;
  localparam int TW     = 32;
  localparam int SHOT_W = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] tcnt;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [TW-1:0] cfg_wdata = '0;
  logic          ts_rd = 1'b0;
  logic [TW-1:0] ts_value;
  logic          ts_new;
  logic          pin_in = 1'b0;
  logic          pin_out;
  logic          pin_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_NS/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt + 1'b1;
  end

  pps_pin_unit #(.TW(TW), .ONESHOT_W(SHOT_W), .SYNC_N(2)) u0 (
    .clk(clk), .rst_n(rst_n), .time_now(tcnt),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ts_rd(ts_rd), .ts_value(ts_value), .ts_new(ts_new),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at time_now=%0d", tag, act, exp, tcnt);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr(input logic [1:0] a, input longint d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = TW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_pulse();
    ts_rd = 1'b1;
    @(negedge clk);
    ts_rd = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint s, ep, hi, t0, tcap, old;
    logic expv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", pin_out, 0);
    check("R1 pin_oe", pin_oe, 1);
    check("R1 ts_value", ts_value, 0);
    check("R1 ts_new", ts_new, 0);

    // R2/R3 periodic sweep; R9 addresses
    for (int p = 1; p <= 7; p++) begin
      for (int k = 0; k < 3; k++) begin
        int off;
        off = (k == 0) ? 0 : ((k == 1) ? 1 : 5);
        ep = (p < 2) ? 2 : p;
        hi = ep - ep / 2;
        wr(2'd2, p);
        s = longint'(tcnt) + 1 + off;
        wr(2'd1, s);
        wr(2'd0, 1);  // enable, mode 0
        for (int n = 0; n < 3 * ep + off + 4; n++) begin
          longint tt;
          tt = longint'(tcnt) - 1;
          expv = (off > 0) && (tt >= s) && (((tt - s) % ep) < hi);
          if (off == 0) check("R2 past start stays low", pin_out, 0);
          else          check("R3 periodic wave", pin_out, expv);
          @(negedge clk);
        end
        wr(2'd0, 0);  // disable
        for (int n = 0; n < ep + 2; n++) begin
          check("R8 disabled low", pin_out, 0);
          @(negedge clk);
        end
        check("R8 oe after disable", pin_oe, 1);
      end
    end

    // R4 oneshot
    t0 = tcnt;
    wr(2'd0, 5);
    check("R4 oneshot stamp", ts_value, t0);
    check("R4 oneshot flag", ts_new, 1);
    for (int i = 0; i < SHOT_W; i++) begin
      check("R4 pulse high", pin_out, 1);
      @(negedge clk);
    end
    check("R4 pulse ends", pin_out, 0);
    @(negedge clk);
    check("R4 stays low", pin_out, 0);

    // R7 read clears
    rd_pulse();
    check("R7 read clears flag", ts_new, 0);
    check("R7 value kept", ts_value, t0);

    // R5/R6 capture
    wr(2'd0, 3);
    check("R6 oe low in capture", pin_oe, 0);
    check("R6 out low in capture", pin_out, 0);
    tcap = tcnt;
    pin_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 capture value", ts_value, tcap + 2);
    check("R5 capture flag", ts_new, 1);
    rd_pulse();
    old = ts_value;
    pin_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R5 falling edge no store", ts_value, old);
    check("R5 falling edge no flag", ts_new, 0);
    tcap = tcnt;
    pin_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 overwrite value", ts_value, tcap + 2);
    pin_in = 1'b0;
    repeat (5) @(negedge clk);
    // R7 read on the same edge as a store
    tcap = tcnt;
    pin_in = 1'b1;
    repeat (2) @(negedge clk);
    rd_pulse();
    check("R7 store beats read", ts_new, 1);
    check("R7 store value", ts_value, tcap + 2);
    rd_pulse();
    pin_in = 1'b0;
    repeat (4) @(negedge clk);

    // R6 pin_in ignored outside capture
    wr(2'd0, 0);
    old = ts_value;
    pin_in = 1'b1;
    repeat (5) @(negedge clk);
    pin_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 ignored value", ts_value, old);
    check("R6 ignored flag", ts_new, 0);
    check("R6 oe when off", pin_oe, 1);

    // R9 reserved mode
    wr(2'd0, 7);
    pin_in = 1'b1;
    repeat (5) @(negedge clk);
    pin_in = 1'b0;
    check("R9 reserved pin low", pin_out, 0);
    check("R9 reserved oe high", pin_oe, 1);
    check("R9 reserved no store", ts_new, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule